// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block holds the burst configuration of a synchronous DRAM and turns each burst request into the column addresses the memory walks through. A controller programs it with a 12-bit mode word, the same word it places on the address pins during a mode-set command. From that word the block takes a burst length, a wrap order, a CAS latency and a write policy. Each burst request then brings a start column and a read/write flag. The block issues one column per clock until the burst is complete.

Bursts can be cut short. A new request on any cycle drops the columns that have not yet been issued. It restarts from the new column at full length, whatever the direction of the old and new bursts. A full-page burst has no natural end. It cycles over every column until a new request or a stop strobe ends it. Mode words with codes outside the legal set are refused. The refusal is flagged, and the previous configuration stays in force.

Top module: `sdram_col_seq`

## Requirements
- R1: Burst length field mode_bits[2:0] gives 1, 2, 4 or 8 beats for codes 000, 001, 010, 011. col_vld is high for exactly that many cycles, starting the cycle after burst_go. burst_last is high only on the final beat.
- R2: With mode_bits[3]=0 (sequential), beat k carries the start column's bits above the burst boundary unchanged. Its low bits are (start low bits + k) modulo the length.
- R3: With mode_bits[3]=1 (interleaved), beat k carries the start column's upper bits unchanged. Its low bits equal the start's low bits XOR k.
- R4: CAS field mode_bits[6:4] codes 010, 011 and 100 drive cas_lat to 2, 3 and 4 from the cycle after mode_wr.
- R5: Length code 111 with mode_bits[3]=0 is a full-page burst. It steps sequentially through all 2^COL_W columns and wraps, and it never raises burst_last. A burst_stop without burst_go makes col_vld low from the next cycle.
- R6: A mode word is refused when it has any of: length code 100, 101 or 110; length 111 with interleave; a CAS code other than 010/011/100; or mode_bits[11:7] other than 00000 or 00100. A refused word sets mode_bad the next cycle and leaves cas_lat and the burst behaviour unchanged. A later legal word clears mode_bad.
- R7: With mode_bits[11:7]=00100, write bursts (burst_wr=1) issue a single beat, while read bursts keep the programmed length.
- R8: A burst_go during a running burst makes the next cycle carry the new start column. The new burst runs its full length, including on a read-to-write change.
- R9: After reset, col_vld, burst_last and mode_bad are 0, cas_lat is 2, and bursts are one beat, sequential, with normal writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_wr | input | 1 | Mode-set strobe |
| mode_bits | input | 12 | Mode word carried with mode_wr |
| burst_go | input | 1 | Burst start strobe; also interrupts a running burst |
| burst_col | input | COL_W | Start column for burst_go |
| burst_wr | input | 1 | 1 = write burst, 0 = read burst |
| burst_stop | input | 1 | Ends the running burst (used for full-page bursts) |
| col_out | output | COL_W | Current column address, zero when idle |
| col_vld | output | 1 | col_out carries a beat |
| burst_last | output | 1 | Current beat is the final one of the burst |
| cas_lat | output | 3 | Programmed CAS latency |
| mode_bad | output | 1 | The last mode word was refused |

## Verification
A wrong beat index or a wrong wrap mask shows in col_out on the very beat it applies to. This is at most one cycle after the burst starts, so every beat of every burst is compared. A wrong stored length or a stale active state shows as col_vld or burst_last being high one cycle too early or too late. A refused mode word that wrongly takes effect shows in cas_lat the next cycle, and in the length of the next burst.

// File: rtl/sdram_col_seq_pkg.sv
package sdram_col_seq_pkg;

  typedef struct packed {
    logic [2:0] len;     // burst length code
    logic       ilv;     // 1 = interleaved wrap order
    logic [2:0] cas;     // CAS latency in cycles
    logic       wr_one;  // writes forced to a single beat
  } mode_t;

  localparam logic [2:0] LEN_PAGE = 3'b111;

  localparam mode_t MODE_RESET = '{len: 3'b000, ilv: 1'b0, cas: 3'd2, wr_one: 1'b0};

  function automatic logic mode_legal(logic [11:0] w);
    logic len_ok, cas_ok, op_ok;
    len_ok = (w[2:0] <= 3'b011) || ((w[2:0] == LEN_PAGE) && !w[3]);
    cas_ok = (w[6:4] == 3'b010) || (w[6:4] == 3'b011) || (w[6:4] == 3'b100);
    op_ok  = (w[11:7] == 5'b00000) || (w[11:7] == 5'b00100);
    return len_ok && cas_ok && op_ok;
  endfunction

  function automatic mode_t mode_unpack(logic [11:0] w);
    mode_t m;
    m.len    = w[2:0];
    m.ilv    = w[3];
    m.cas    = w[6:4];
    m.wr_one = w[9];
    return m;
  endfunction

endpackage

// File: rtl/sdram_col_seq_mode.sv
module sdram_col_seq_mode
  import sdram_col_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [11:0] wr_bits,
  output mode_t       mode_q,
  output logic        bad_q
);

  mode_t mode_d;
  logic  bad_d;

  always_comb begin
    mode_d = mode_q;
    bad_d  = bad_q;
    if (wr_en) begin
      if (mode_legal(wr_bits)) begin
        mode_d = mode_unpack(wr_bits);
        bad_d  = 1'b0;
      end else begin
        bad_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RESET;
      bad_q  <= 1'b0;
    end else if (wr_en) begin
      mode_q <= mode_d;
      bad_q  <= bad_d;
    end
  end

endmodule

// File: rtl/sdram_col_seq_ctl.sv
module sdram_col_seq_ctl
  import sdram_col_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_wr,
  input  logic             stop,
  input  logic [COL_W-1:0] go_col,
  input  logic [2:0]       len_code,
  input  logic             ilv_mode,
  input  logic             wr_one,
  output logic             active_q,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] idx_q,
  output logic [COL_W-1:0] mask_q,
  output logic             ilv_q,
  output logic             last
);

  localparam logic [COL_W-1:0] ALL_ONES = {COL_W{1'b1}};

  logic             full_q, full_d, single;
  logic [COL_W-1:0] mask_new;
  logic             active_d;
  logic [COL_W-1:0] idx_d;

  always_comb begin
    single = go_wr && wr_one;
    unique case (len_code)
      3'b000:  mask_new = COL_W'(0);
      3'b001:  mask_new = COL_W'(1);
      3'b010:  mask_new = COL_W'(3);
      3'b011:  mask_new = COL_W'(7);
      default: mask_new = ALL_ONES;
    endcase
    if (single) mask_new = COL_W'(0);
    full_d = (len_code == LEN_PAGE) && !single;
  end

  assign last = active_q && !full_q && (idx_q == mask_q);

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    if (go) begin
      active_d = 1'b1;
      idx_d    = '0;
    end else if (active_q) begin
      if (stop || last) active_d = 1'b0;
      else              idx_d    = idx_q + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
      full_q <= 1'b0;
    end else if (go) begin
      base_q <= go_col;
      mask_q <= mask_new;
      ilv_q  <= ilv_mode;
      full_q <= full_d;
    end
  end

endmodule

// File: rtl/sdram_col_seq_gen.sv
module sdram_col_seq_gen #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);

  logic [COL_W-1:0] low_seq, low_ilv;

  always_comb begin
    low_seq = (base + idx) & mask;
    low_ilv = (base ^ idx) & mask;
    col     = (base & ~mask) | (ilv ? low_ilv : low_seq);
  end

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import sdram_col_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [11:0]      mode_bits,
  input  logic             burst_go,
  input  logic [COL_W-1:0] burst_col,
  input  logic             burst_wr,
  input  logic             burst_stop,
  output logic [COL_W-1:0] col_out,
  output logic             col_vld,
  output logic             burst_last,
  output logic [2:0]       cas_lat,
  output logic             mode_bad
);

  logic [1:0]       rst_pipe;
  logic             rst_n_q;
  mode_t            mode_q;
  logic             active_q, ilv_q, last;
  logic [COL_W-1:0] base_q, idx_q, mask_q, col_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_q = rst_pipe[1];

  sdram_col_seq_mode u_mode (
    .clk     (clk),
    .rst_n   (rst_n_q),
    .wr_en   (mode_wr),
    .wr_bits (mode_bits),
    .mode_q  (mode_q),
    .bad_q   (mode_bad)
  );

  sdram_col_seq_ctl #(.COL_W(COL_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n_q),
    .go       (burst_go),
    .go_wr    (burst_wr),
    .stop     (burst_stop),
    .go_col   (burst_col),
    .len_code (mode_q.len),
    .ilv_mode (mode_q.ilv),
    .wr_one   (mode_q.wr_one),
    .active_q (active_q),
    .base_q   (base_q),
    .idx_q    (idx_q),
    .mask_q   (mask_q),
    .ilv_q    (ilv_q),
    .last     (last)
  );

  sdram_col_seq_gen #(.COL_W(COL_W)) u_gen (
    .base (base_q),
    .idx  (idx_q),
    .mask (mask_q),
    .ilv  (ilv_q),
    .col  (col_raw)
  );

  assign col_out    = active_q ? col_raw : '0;
  assign col_vld    = active_q;
  assign burst_last = last;
  assign cas_lat    = mode_q.cas;

endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             burst_go,
  input logic [COL_W-1:0] burst_col,
  input logic             burst_stop,
  input logic [COL_W-1:0] col_out,
  input logic             col_vld,
  input logic             burst_last,
  input logic [2:0]       cas_lat,
  input logic             mode_bad
);

  p_last_in_beat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    burst_last |-> col_vld);

  p_idle_stays_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_vld && !burst_go) |=> !col_vld);

  p_cas_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 3'd2) || (cas_lat == 3'd3) || (cas_lat == 3'd4));

  p_stop_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_stop && !burst_go) |=> !col_vld);

  p_refused_keeps_cas_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_bad) |-> $stable(cas_lat));

  p_new_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_go |=> (col_vld && col_out == $past(burst_col)));

endmodule

bind sdram_col_seq sdram_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_q),
  .burst_go   (burst_go),
  .burst_col  (burst_col),
  .burst_stop (burst_stop),
  .col_out    (col_out),
  .col_vld    (col_vld),
  .burst_last (burst_last),
  .cas_lat    (cas_lat),
  .mode_bad   (mode_bad)
);

// File: tb/sdram_col_seq_bench.sv
module sdram_col_seq_bench;

  localparam int COL_W = 10;
  localparam int PAGE  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             mode_wr, burst_go, burst_wr, burst_stop;
  logic [11:0]      mode_bits;
  logic [COL_W-1:0] burst_col;
  logic [COL_W-1:0] col_out;
  logic             col_vld, burst_last, mode_bad;
  logic [2:0]       cas_lat;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  sdram_col_seq #(.COL_W(COL_W)) u_sdram_col_seq (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_bits(mode_bits),
    .burst_go(burst_go), .burst_col(burst_col), .burst_wr(burst_wr),
    .burst_stop(burst_stop), .col_out(col_out), .col_vld(col_vld),
    .burst_last(burst_last), .cas_lat(cas_lat), .mode_bad(mode_bad)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp<=100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_col(int start, int k, int len, bit ilv);
    int lo = start % len;
    int hi = start - lo;
    int nlo = ilv ? (lo ^ k) : ((lo + k) % len);
    return (hi + nlo) % PAGE;
  endfunction

  task automatic set_mode(logic [11:0] w);
    mode_wr = 1'b1; mode_bits = w;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic issue(int col, bit wr);
    burst_go = 1'b1; burst_col = COL_W'(col); burst_wr = wr;
    @(negedge clk);
    burst_go = 1'b0;
  endtask

  // Checks n beats; beat 0 is visible at entry. Ends on the negedge of beat n-1.
  task automatic beats(string req, int start, int n, int len, bit ilv, bit ends);
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      chk({req, " vld"}, 32'(col_vld), 1);
      chk({req, " col"}, 32'(col_out), 32'(exp_col(start, k, len, ilv)));
      chk({req, " last"}, 32'(burst_last), 32'(ends && (k == n - 1)));
    end
  endtask

  task automatic idle_after(string req);
    @(negedge clk);
    chk({req, " idle"}, 32'(col_vld), 0);
  endtask

  task automatic t_reset;
    chk("R9 vld", 32'(col_vld), 0);
    chk("R9 last", 32'(burst_last), 0);
    chk("R9 bad", 32'(mode_bad), 0);
    chk("R9 cas", 32'(cas_lat), 2);
    issue(12'h1A3, 1'b1);
    beats("R9 default burst", 32'h1A3, 1, 1, 1'b0, 1'b1);
    idle_after("R9");
  endtask

  task automatic t_lengths;
    for (int c = 0; c < 4; c++) begin
      set_mode(12'h030 | 12'(c));
      issue(32'h2B5, 1'b0);
      beats("R1 R2 seq", 32'h2B5, 1 << c, 1 << c, 1'b0, 1'b1);
      idle_after("R1");
    end
  endtask

  task automatic t_interleave;
    set_mode(12'h02B);
    issue(32'h15D, 1'b0);
    beats("R3 ilv8", 32'h15D, 8, 8, 1'b1, 1'b1);
    idle_after("R3");
    set_mode(12'h02A);
    issue(32'h0F6, 1'b1);
    beats("R3 ilv4", 32'h0F6, 4, 4, 1'b1, 1'b1);
    idle_after("R3");
  endtask

  task automatic t_cas;
    set_mode(12'h032); chk("R4 cas3", 32'(cas_lat), 3);
    set_mode(12'h042); chk("R4 cas4", 32'(cas_lat), 4);
    set_mode(12'h022); chk("R4 cas2", 32'(cas_lat), 2);
  endtask

  task automatic t_full_page;
    set_mode(12'h027);
    issue(32'h3FE, 1'b0);
    beats("R5 page wrap", 32'h3FE, PAGE + 3, PAGE, 1'b0, 1'b0);
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk("R5 stop", 32'(col_vld), 0);
    @(negedge clk);
    chk("R5 stays idle", 32'(col_vld), 0);
  endtask

  task automatic t_refused;
    set_mode(12'h032);
    chk("R6 clean", 32'(mode_bad), 0);
    set_mode(12'h034);
    chk("R6 len100 bad", 32'(mode_bad), 1);
    chk("R6 cas kept", 32'(cas_lat), 3);
    issue(32'h011, 1'b0);
    beats("R6 len kept", 32'h011, 4, 4, 1'b0, 1'b1);
    idle_after("R6");
    set_mode(12'h02F);
    chk("R6 ilv page bad", 32'(mode_bad), 1);
    set_mode(12'h012);
    chk("R6 cas001 bad", 32'(mode_bad), 1);
    chk("R6 cas kept2", 32'(cas_lat), 3);
    set_mode(12'h0B2);
    chk("R6 op bad", 32'(mode_bad), 1);
    issue(32'h206, 1'b1);
    beats("R6 order kept", 32'h206, 4, 4, 1'b0, 1'b1);
    idle_after("R6");
    set_mode(12'h041);
    chk("R6 cleared", 32'(mode_bad), 0);
    chk("R6 new cas", 32'(cas_lat), 4);
  endtask

  task automatic t_single_write;
    set_mode(12'h233);
    chk("R7 legal", 32'(mode_bad), 0);
    issue(32'h0C9, 1'b1);
    beats("R7 write one", 32'h0C9, 1, 1, 1'b0, 1'b1);
    idle_after("R7");
    issue(32'h0C9, 1'b0);
    beats("R7 read full", 32'h0C9, 8, 8, 1'b0, 1'b1);
    idle_after("R7");
  endtask

  task automatic t_interrupt;
    set_mode(12'h033);
    issue(32'h100, 1'b0);
    beats("R8 first", 32'h100, 3, 8, 1'b0, 1'b0);
    issue(32'h2C4, 1'b1);
    beats("R8 restarted", 32'h2C4, 8, 8, 1'b0, 1'b1);
    idle_after("R8");
    set_mode(12'h02B);
    issue(32'h05A, 1'b1);
    issue(32'h371, 1'b0);
    beats("R8 back to back", 32'h371, 8, 8, 1'b1, 1'b1);
    idle_after("R8");
  endtask

  initial begin
    rst_n = 1'b0; mode_wr = 1'b0; mode_bits = '0;
    burst_go = 1'b0; burst_col = '0; burst_wr = 1'b0; burst_stop = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 in reset", 32'(col_vld), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_lengths();
    t_interleave();
    t_cas();
    t_full_page();
    t_refused();
    t_single_write();
    t_interrupt();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule